// File: doc/BRIEF.md
# Ripple-Carry Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit of parameterised width (32 bits by default). It is a chain of identical one-bit cells. Each cell holds a full adder, a conditional inverter on its second operand and a four-way result selector. The carry runs from the least significant cell to the most significant one. A two-bit operation code selects bitwise AND, bitwise OR, the adder output or a signed set-on-less-than.

A single negate control does two jobs at once. It inverts the second operand in every cell, and it supplies the carry into cell 0. Raising it turns the adder into a subtractor, since A + ~B + 1 equals A − B. A small flag unit after the chain produces three flags:
- the carry out of the top cell;
- signed overflow, taken as the XOR of the carry into the top cell and the carry out of it;
- a zero flag, computed from the result.

The block contains no registers and no state machine. An operation is a fixed combinational path: operands and controls go into the cell chain, then through the flag unit, to the outputs.

Top module: `rip_alu`

## Requirements
- R1: With `op_sel` = 0 the result is the bitwise AND of `in_a` and the effective second operand. The effective operand is `in_b` when `b_negate` = 0 and `~in_b` when `b_negate` = 1.
- R2: With `op_sel` = 1 the result is the bitwise OR of `in_a` and the effective second operand, as defined in R1.
- R3: With `op_sel` = 2 and `b_negate` = 0 the result is (`in_a` + `in_b`) mod 2^WIDTH, with no carry entering bit 0.
- R4: With `op_sel` = 2 and `b_negate` = 1 the result is (`in_a` + ~`in_b` + 1) mod 2^WIDTH, which is `in_a` − `in_b`.
- R5: For `op_sel` 2 and 3, `carry_out` is the carry leaving the most significant cell, that is bit WIDTH of `in_a` + effective operand + `b_negate`. This bit is excluded from `result`.
- R6: For `op_sel` 2 and 3, `overflow` is 1 exactly when the two's-complement sum or difference falls outside the signed WIDTH-bit range. This is the case when the carry into the top cell differs from the carry out of it.
- R7: `zero` is 1 exactly when every bit of `result` is 0. After a subtract it is therefore 1 exactly when `in_a` equals `in_b`.
- R8: With `op_sel` = 3 and `b_negate` = 1, `result` bit 0 is 1 exactly when signed `in_a` < signed `in_b`, and all other result bits are 0. This holds even when the difference overflows.
- R9: For `op_sel` 0 and 1, `carry_out` and `overflow` are both 0.
- R10: In a 4-bit configuration, 7+3 and (−4)+(−5) raise `overflow`, while 5+2 and (−3)+(−5) do not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation code: 0 AND, 1 OR, 2 add/subtract, 3 set-on-less-than |
| b_negate | input | 1 | 1 inverts the second operand and forces the carry into cell 0 |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| result | output | WIDTH | Selected operation result |
| carry_out | output | 1 | Carry out of the most significant cell (arithmetic codes only) |
| overflow | output | 1 | Signed overflow (arithmetic codes only) |
| zero | output | 1 | All result bits are 0 |

## Verification
The hardest case to reach is a set-on-less-than whose difference overflows, such as −8 compared with 7. There the sign bit of the difference points the wrong way, and only the overflow correction gives the right answer. A second hard case is an addition in which the carry into the top cell differs from the carry out of it. The bench instantiates a 4-bit configuration and sweeps every operand pair under every operation code and both negate settings. This sweep reaches both cases many times, and the bench computes every expected value from integer arithmetic. The four named overflow corner cases are also driven individually.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_AND  = 2'd0,
        OP_OR   = 2'd1,
        OP_SUM  = 2'd2,
        OP_LESS = 2'd3
    } alu_op_e;

    function automatic logic is_arith(input alu_op_e op);
        return (op == OP_SUM) || (op == OP_LESS);
    endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    less_i,
    input  logic    cin_i,
    input  logic    bneg_i,
    input  alu_op_e op_i,
    output logic    res_o,
    output logic    sum_o,
    output logic    cout_o
);

    logic b_eff;

    // Second operand, conditionally inverted for subtraction
    assign b_eff  = b_i ^ bneg_i;

    // Full adder
    assign sum_o  = a_i ^ b_eff ^ cin_i;
    assign cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_eff;
            OP_OR:   res_o = a_i | b_eff;
            OP_SUM:  res_o = sum_o;
            OP_LESS: res_o = less_i;
        endcase
    end

endmodule

// File: rtl/alu_chain.sv
module alu_chain
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] less_i,
    input  logic             bneg_i,
    input  alu_op_e          op_i,
    output logic [WIDTH-1:0] res_o,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH:0]   carry_o
);

    // The negate line also feeds the carry into cell 0
    assign carry_o[0] = bneg_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        alu_slice u_slice (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .less_i (less_i[i]),
            .cin_i  (carry_o[i]),
            .bneg_i (bneg_i),
            .op_i   (op_i),
            .res_o  (res_o[i]),
            .sum_o  (sum_o[i]),
            .cout_o (carry_o[i+1])
        );
    end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] res_i,
    input  logic             sum_msb_i,
    input  logic             cin_top_i,
    input  logic             cout_top_i,
    output logic             set_o,
    output logic             cout_o,
    output logic             ovf_o,
    output logic             zero_o
);

    logic ovf_raw;
    logic arith;

    assign ovf_raw = cin_top_i ^ cout_top_i;
    assign arith   = is_arith(op_i);

    // Sign corrected by overflow gives the true signed comparison
    assign set_o   = sum_msb_i ^ ovf_raw;

    assign cout_o  = arith & cout_top_i;
    assign ovf_o   = arith & ovf_raw;
    assign zero_o  = ~|res_i;

endmodule

// File: rtl/rip_alu.sv
module rip_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       op_sel,
    input  logic             b_negate,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow,
    output logic             zero
);

    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic [WIDTH-1:0] less_vec;
    logic [WIDTH-1:0] sum_vec;
    logic [WIDTH:0]   carry_vec;
    logic             set_bit;

    assign op       = alu_op_e'(op_sel);
    assign less_vec = {{(WIDTH-1){1'b0}}, set_bit};

    alu_chain #(.WIDTH(WIDTH)) u_chain (
        .a_i     (in_a),
        .b_i     (in_b),
        .less_i  (less_vec),
        .bneg_i  (b_negate),
        .op_i    (op),
        .res_o   (result),
        .sum_o   (sum_vec),
        .carry_o (carry_vec)
    );

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .op_i       (op),
        .res_i      (result),
        .sum_msb_i  (sum_vec[MSB]),
        .cin_top_i  (carry_vec[MSB]),
        .cout_top_i (carry_vec[WIDTH]),
        .set_o      (set_bit),
        .cout_o     (carry_out),
        .ovf_o      (overflow),
        .zero_o     (zero)
    );

endmodule

// File: rtl/rip_alu_chk.sv
module rip_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [1:0]       op_sel,
    input logic             b_negate,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             overflow,
    input logic             zero
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             known;

    assign b_eff = b_negate ? ~in_b : in_b;
    assign known = !$isunknown({op_sel, b_negate, in_a, in_b, result,
                                carry_out, overflow, zero});

    always_comb begin
        if (known) begin
            // R9: logic codes never raise arithmetic flags
            p_logic_flags_clear_r9: assert (op_sel[1] || (!carry_out && !overflow))
                else $error("logic op raised carry or overflow");

            // R7: zero flag agrees with result
            p_zero_match_r7: assert (zero == (result == '0))
                else $error("zero flag mismatch");

            // R6: overflow needs like-signed operands and a sign flip
            p_no_overflow_r6: assert (!(op_sel == 2'd2 && overflow) ||
                                      (in_a[MSB] == b_eff[MSB] && result[MSB] != in_a[MSB]))
                else $error("overflow with unlike signs or no sign change");

            // R8: set-on-less-than leaves upper bits clear
            p_less_upper_r8: assert (op_sel != 2'd3 || (result >> 1) == '0)
                else $error("set-on-less-than upper bits nonzero");

            // R4: subtract of equal operands gives zero
            p_sub_equal_r4: assert (!(op_sel == 2'd2 && b_negate && in_a == in_b) || zero)
                else $error("equal subtract not zero");
        end
    end

endmodule

bind rip_alu rip_alu_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/rip_alu_tb_top.sv
module rip_alu_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int SPAN       = 1 << W;

    logic         clk = 1'b0;
    logic [1:0]   op_sel;
    logic         b_negate;
    logic [W-1:0] in_a;
    logic [W-1:0] in_b;
    logic [W-1:0] result;
    logic         carry_out;
    logic         overflow;
    logic         zero;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rip_alu #(.WIDTH(W)) dut_i (
        .op_sel    (op_sel),
        .b_negate  (b_negate),
        .in_a      (in_a),
        .in_b      (in_b),
        .result    (result),
        .carry_out (carry_out),
        .overflow  (overflow),
        .zero      (zero)
    );

    task automatic check(input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s op=%0d neg=%0d a=%0d b=%0d actual=%0d expected=%0d",
                     req, what, op_sel, b_negate, in_a, in_b, actual, expected);
        end
    endtask

    task automatic apply(input int op, input int neg, input int a, input int b);
        @(posedge clk);
        op_sel   <= 2'(op);
        b_negate <= 1'(neg);
        in_a     <= W'(a);
        in_b     <= W'(b);
        @(negedge clk);
    endtask

    task automatic verify_all();
        int be, full, sum, cy, sa, sbe, ssum, ov, lt, exp_r;
        be   = (b_negate ? ~int'(in_b) : int'(in_b)) & (SPAN - 1);
        full = int'(in_a) + be + int'(b_negate);
        sum  = full & (SPAN - 1);
        cy   = (full >> W) & 1;
        sa   = (int'(in_a) >= SPAN/2) ? int'(in_a) - SPAN : int'(in_a);
        sbe  = (be >= SPAN/2) ? be - SPAN : be;
        ssum = sa + sbe + int'(b_negate);
        ov   = (ssum > SPAN/2 - 1 || ssum < -SPAN/2) ? 1 : 0;
        lt   = (sa < ((int'(in_b) >= SPAN/2) ? int'(in_b) - SPAN : int'(in_b))) ? 1 : 0;
        case (op_sel)
            2'd0: begin
                exp_r = int'(in_a) & be;
                check("R1", "and", int'(result), exp_r);
                check("R9", "carry", int'(carry_out), 0);
                check("R9", "ovf", int'(overflow), 0);
            end
            2'd1: begin
                exp_r = int'(in_a) | be;
                check("R2", "or", int'(result), exp_r);
                check("R9", "carry", int'(carry_out), 0);
                check("R9", "ovf", int'(overflow), 0);
            end
            2'd2: begin
                exp_r = sum;
                check(b_negate ? "R4" : "R3", "sum", int'(result), exp_r);
                check("R5", "carry", int'(carry_out), cy);
                check("R6", "ovf", int'(overflow), ov);
            end
            default: begin
                exp_r = b_negate ? lt : (((sum >> (W-1)) & 1) ^ ov);
                check("R8", "less", int'(result), exp_r);
                check("R5", "carry", int'(carry_out), cy);
                check("R6", "ovf", int'(overflow), ov);
            end
        endcase
        check("R7", "zero", int'(zero), (exp_r == 0) ? 1 : 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        op_sel   = 2'd0;
        b_negate = 1'b0;
        in_a     = '0;
        in_b     = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // Quiet state: all inputs low
        check("R7", "idle zero", int'(zero), 1);
        check("R1", "idle result", int'(result), 0);

        // R10: named overflow corner cases (4-bit)
        apply(2, 0, 7, 3);
        check("R10", "7+3 ovf", int'(overflow), 1);
        check("R10", "7+3 sum", int'(result), 10);
        apply(2, 0, 12, 11);
        check("R10", "-4-5 ovf", int'(overflow), 1);
        check("R10", "-4-5 sum", int'(result), 7);
        apply(2, 0, 5, 2);
        check("R10", "5+2 ovf", int'(overflow), 0);
        apply(2, 0, 13, 11);
        check("R10", "-3-5 ovf", int'(overflow), 0);
        check("R10", "-3-5 sum", int'(result), 8);

        // R8: overflowing compare -8 < 7
        apply(3, 1, 8, 7);
        check("R8", "-8<7", int'(result), 1);
        apply(3, 1, 7, 8);
        check("R8", "7<-8", int'(result), 0);

        // Exhaustive sweep over codes, negate and operands
        for (int op = 0; op < 4; op++) begin
            for (int neg = 0; neg < 2; neg++) begin
                for (int a = 0; a < SPAN; a++) begin
                    for (int b = 0; b < SPAN; b++) begin
                        apply(op, neg, a, b);
                        verify_all();
                    end
                end
            end
        end
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

endmodule